// File: doc/BRIEF.md
# Bresenham Line Step Engine

This block walks a straight line one pixel at a time from a start coordinate, using step constants that the host has already worked out. The host supplies the start X and Y, an initial error term, an axial step constant, a diagonal step constant, a pixel count and three orientation bits. The orientation bits say which axis is the major one and whether X and Y move up or down. A start strobe latches all of these values. From the next cycle onward, the engine presents one coordinate per cycle with a valid flag.

Every accepted pixel moves the position one unit along the major axis. The sign of the running error term decides whether the position also moves one unit on the minor axis. If it does, the error term takes the diagonal constant. If it does not, the error term takes the axial constant.

A downstream consumer can hold the engine with a stall input. A stalled pixel stays on the outputs unchanged until it is taken. After the last pixel is taken, a one-cycle done pulse marks the end of the line.

Top module: `line_stepper`

## Requirements
- R1: While reset is held and after it is released, `pix_valid` and `done` are 0 until a start is accepted.
- R2: A start accepted at a clock edge makes `pix_valid` 1 in the following cycle, with `pix_x`/`pix_y` equal to the start coordinate sampled at that edge.
- R3: A line with pixel count N presents exactly N+1 pixels. `done` is 1 for exactly one cycle, the cycle after the last pixel is taken, and `pix_valid` is 0 in that cycle.
- R4: When `y_major` is 0, every step changes X by one unit. When `y_major` is 1, every step changes Y by one unit.
- R5: `inc_x`=1 moves X by +1 and `inc_x`=0 moves X by -1. `inc_y`=1 moves Y by +1 (down the screen) and `inc_y`=0 moves Y by -1. Coordinates wrap modulo 2^12.
- R6: If the error term is non-negative (bit 13 clear, 14-bit two's complement), the step also moves the minor axis one unit and adds the diagonal constant. Otherwise the minor axis holds and the axial constant is added. The error term starts at the loaded initial value.
- R7: A pixel is taken in a cycle where `pix_valid` is 1 and `stall` is 0. While `stall` is 1, the presented pixel and all internal state stay unchanged and no pixel is lost.
- R8: A start strobe raised while `pix_valid` is 1 has no effect on the line in progress.
- R9: All line inputs (coordinates, constants, count, orientation) are sampled only when a start is accepted. Changing them during a line has no effect on the pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a line when idle |
| stall | input | 1 | Hold the current pixel |
| start_x | input | 12 | Start X coordinate |
| start_y | input | 12 | Start Y coordinate |
| err_init | input | 14 | Initial error term, signed |
| axial_k | input | 14 | Axial step constant, signed |
| diag_k | input | 14 | Diagonal step constant, signed |
| pix_count | input | 12 | Pixel count minus one |
| y_major | input | 1 | 1: Y is the major axis |
| inc_x | input | 1 | 1: X increases |
| inc_y | input | 1 | 1: Y increases (down) |
| pix_x | output | 12 | Current pixel X |
| pix_y | output | 12 | Current pixel Y |
| pix_valid | output | 1 | Pixel on `pix_x`/`pix_y` is valid |
| done | output | 1 | One-cycle end-of-line pulse |

## Verification
The assertions assume that `stall` and `start` are clean levels sampled at the clock edge. They also assume that reset is applied before any activity. They make no assumption about the constants, because the error arithmetic is allowed to wrap. The stimulus drives every input half a cycle away from the active edge. It draws constants, counts, orientations and stall patterns at random within their full signed ranges, keeping counts small so that many lines fit in a run. It also raises stray start strobes and changes the input values in the middle of lines.

// File: rtl/line_stepper_pkg.sv
package line_stepper_pkg;
  typedef struct packed {
    logic y_major;
    logic inc_x;
    logic inc_y;
  } orient_t;
endpackage

// File: rtl/stepper_ctl.sv
module stepper_ctl #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stall,
  input  logic [CNT_W-1:0] cnt_init,
  output logic             busy_o,
  output logic             load_o,
  output logic             adv_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             last, fin;

  always_comb begin
    last   = (cnt_q == '0);
    load_o = start && !busy_q;
    adv_o  = busy_q && !stall && !last;
    fin    = busy_q && !stall && last;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = cnt_init;
    end else if (fin) begin
      busy_d = 1'b0;
    end else if (adv_o) begin
      cnt_d  = cnt_q - 1'b1;
    end
    done_d = fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R3
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && stall |=> busy_q && $stable(cnt_q));
  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && !last |=> busy_q && (cnt_q == $past(cnt_q) - CNT_W'($past(adv_o))));
endmodule

// File: rtl/stepper_err.sv
module stepper_err #(
  parameter int ERR_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [ERR_W-1:0] err_init,
  input  logic [ERR_W-1:0] axial_k,
  input  logic [ERR_W-1:0] diag_k,
  output logic             minor_step
);
  logic [ERR_W-1:0] err_q, err_d;
  logic [ERR_W-1:0] axial_q, axial_d;
  logic [ERR_W-1:0] diag_q, diag_d;

  always_comb begin
    minor_step = !err_q[ERR_W-1];
    err_d   = err_q;
    axial_d = axial_q;
    diag_d  = diag_q;
    if (load) begin
      err_d   = err_init;
      axial_d = axial_k;
      diag_d  = diag_k;
    end else if (adv) begin
      err_d = err_q + (minor_step ? diag_q : axial_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= '0;
      axial_q <= '0;
      diag_q  <= '0;
    end else begin
      err_q   <= err_d;
      axial_q <= axial_d;
      diag_q  <= diag_d;
    end
  end

  // R7
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !adv |=> $stable(err_q));
  // R9
  const_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(axial_q) && $stable(diag_q));
endmodule

// File: rtl/stepper_axis.sv
module stepper_axis #(
  parameter int COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               inc,
  input  logic [COORD_W-1:0] start_val,
  output logic [COORD_W-1:0] coord
);
  logic [COORD_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (load)
      pos_d = start_val;
    else if (step)
      pos_d = inc ? pos_q + COORD_W'(1) : pos_q - COORD_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign coord = pos_q;

  // R7
  pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !step |=> $stable(pos_q));
  // R2
  pos_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pos_q == $past(start_val));
endmodule

// File: rtl/line_stepper.sv
module line_stepper
  import line_stepper_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int ERR_W   = 14,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               stall,
  input  logic [COORD_W-1:0] start_x,
  input  logic [COORD_W-1:0] start_y,
  input  logic [ERR_W-1:0]   err_init,
  input  logic [ERR_W-1:0]   axial_k,
  input  logic [ERR_W-1:0]   diag_k,
  input  logic [CNT_W-1:0]   pix_count,
  input  logic               y_major,
  input  logic               inc_x,
  input  logic               inc_y,
  output logic [COORD_W-1:0] pix_x,
  output logic [COORD_W-1:0] pix_y,
  output logic               pix_valid,
  output logic               done
);
  localparam int NAX = 2;

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic    busy, load, adv, minor_step;
  orient_t orient_q, orient_d;

  stepper_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_sync_q), .start(start), .stall(stall),
    .cnt_init(pix_count), .busy_o(busy), .load_o(load), .adv_o(adv),
    .done_o(done)
  );

  stepper_err #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_sync_q), .load(load), .adv(adv),
    .err_init(err_init), .axial_k(axial_k), .diag_k(diag_k),
    .minor_step(minor_step)
  );

  always_comb begin
    orient_d = orient_q;
    if (load) orient_d = '{y_major: y_major, inc_x: inc_x, inc_y: inc_y};
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) orient_q <= '0;
    else             orient_q <= orient_d;
  end

  logic [NAX-1:0][COORD_W-1:0] start_v, coord_v;
  logic [NAX-1:0]              inc_v, step_v;

  assign start_v[0] = start_x;
  assign start_v[1] = start_y;
  assign inc_v[0]   = orient_q.inc_x;
  assign inc_v[1]   = orient_q.inc_y;

  for (genvar i = 0; i < NAX; i++) begin : g_axis
    localparam logic IS_Y = (i == 1);
    assign step_v[i] = adv && ((IS_Y == orient_q.y_major) || minor_step);
    stepper_axis #(.COORD_W(COORD_W)) u_axis (
      .clk(clk), .rst_n(rst_sync_q), .load(load), .step(step_v[i]),
      .inc(inc_v[i]), .start_val(start_v[i]), .coord(coord_v[i])
    );
  end

  assign pix_x     = coord_v[0];
  assign pix_y     = coord_v[1];
  assign pix_valid = busy;

  // R4
  major_move_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    adv |=> ($past(orient_q.y_major) ? (pix_y != $past(pix_y)) : (pix_x != $past(pix_x))));
  // R7
  stall_pix_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    pix_valid && stall |=> pix_valid && $stable(pix_x) && $stable(pix_y));
  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !pix_valid && !start |=> !pix_valid);
endmodule

// File: tb/line_stepper_bench.sv
module line_stepper_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stall = 1'b0;
  logic [11:0] start_x = '0, start_y = '0, pix_count = '0;
  logic [13:0] err_init = '0, axial_k = '0, diag_k = '0;
  logic y_major = 1'b0, inc_x = 1'b0, inc_y = 1'b0;
  logic [11:0] pix_x, pix_y;
  logic pix_valid, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  line_stepper u_line_stepper (
    .clk(clk), .rst_n(rst_n), .start(start), .stall(stall),
    .start_x(start_x), .start_y(start_y), .err_init(err_init),
    .axial_k(axial_k), .diag_k(diag_k), .pix_count(pix_count),
    .y_major(y_major), .inc_x(inc_x), .inc_y(inc_y),
    .pix_x(pix_x), .pix_y(pix_y), .pix_valid(pix_valid), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] step1(input logic [11:0] v, input bit up);
    return up ? v + 12'd1 : v - 12'd1;
  endfunction

  // Draws one line; checks every presented pixel against a bench model.
  task automatic draw(input logic [11:0] sx, input logic [11:0] sy,
                      input logic [13:0] e0, input logic [13:0] ak,
                      input logic [13:0] dk, input logic [11:0] n,
                      input bit ym, input bit ix, input bit iy,
                      input int stall_pct, input bit disturb);
    logic [11:0] mx, my;
    logic [13:0] me;
    int left, seen;
    @(negedge clk);
    start_x = sx; start_y = sy; err_init = e0; axial_k = ak; diag_k = dk;
    pix_count = n; y_major = ym; inc_x = ix; inc_y = iy; start = 1'b1;
    stall = 1'b0;
    mx = sx; my = sy; me = e0; left = int'(n); seen = 0;
    @(negedge clk);
    start = 1'b0;
    // R2: first pixel is the start coordinate
    check(pix_valid && pix_x == sx && pix_y == sy, "R2", "first pixel",
          {pix_valid, pix_x, pix_y}, {1'b1, sx, sy});
    for (int guard = 0; guard < 4000; guard++) begin
      if (!pix_valid) break;
      // R4 R5 R6 R7 R9: presented pixel matches the model
      check(pix_x == mx && pix_y == my, "R6", "pixel coord",
            {pix_x, pix_y}, {mx, my});
      check(!done, "R3", "done during line", done, 0);
      stall = ($urandom_range(99) < stall_pct);
      if (disturb) begin
        // R8 R9: stray start and changed inputs during the line
        start = ($urandom_range(3) == 0);
        start_x = 12'($urandom); start_y = 12'($urandom);
        err_init = 14'($urandom); axial_k = 14'($urandom); diag_k = 14'($urandom);
        pix_count = 12'($urandom); y_major = 1'($urandom);
        inc_x = 1'($urandom); inc_y = 1'($urandom);
      end
      if (!stall) begin
        seen++;
        if (left > 0) begin
          if (ym) begin
            my = step1(my, iy);
            if (!me[13]) begin mx = step1(mx, ix); me = me + dk; end
            else me = me + ak;
          end else begin
            mx = step1(mx, ix);
            if (!me[13]) begin my = step1(my, iy); me = me + dk; end
            else me = me + ak;
          end
        end
        left--;
      end
      @(negedge clk);
    end
    start = 1'b0;
    stall = 1'b0;
    // R3: count+1 pixels, then a single done pulse with valid low
    check(seen == int'(n) + 1, disturb ? "R8" : "R3", "pixel total", seen, int'(n) + 1);
    check(done && !pix_valid, "R3", "done pulse", {done, pix_valid}, 2'b10);
    @(negedge clk);
    check(!done && !pix_valid, "R3", "done width", {done, pix_valid}, 2'b00);
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    check(!pix_valid && !done, "R1", "in reset", {pix_valid, done}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!pix_valid && !done, "R1", "after reset", {pix_valid, done}, 0);

    // Directed corners
    draw(12'd10, 12'd20, 14'd0, 14'd0, 14'd0, 12'd0, 0, 1, 1, 0, 0);        // R3 single pixel
    draw(12'd5, 12'd5, 14'h3fff, 14'h3fff, 14'd0, 12'd6, 0, 1, 1, 0, 0);    // R4 R6 pure X, no minor
    draw(12'd5, 12'd5, 14'h3fff, 14'h3fff, 14'd0, 12'd6, 1, 0, 0, 0, 0);    // R4 R5 pure -Y
    draw(12'd100, 12'd50, 14'd0, 14'd0, 14'd0, 12'd5, 0, 0, 1, 0, 0);       // R6 45-degree, -X +Y
    draw(12'hfff, 12'd0, 14'd0, 14'd0, 14'd0, 12'd3, 1, 1, 0, 0, 0);        // R5 wrap both axes
    draw(12'd7, 12'd9, 14'd2, 14'd4, 14'h3ff8, 12'd12, 0, 1, 1, 60, 0);     // R7 heavy stall
    draw(12'd30, 12'd30, 14'd1, 14'd6, 14'h3ffa, 12'd10, 1, 1, 1, 30, 1);   // R8 R9 disturbances

    // Random lines
    for (int t = 0; t < 150; t++) begin
      draw(12'($urandom), 12'($urandom), 14'($urandom), 14'($urandom),
           14'($urandom), 12'($urandom_range(24)), 1'($urandom), 1'($urandom),
           1'($urandom), $urandom_range(50), 1'($urandom_range(3) == 0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule